// File: doc/BRIEF.md
# Physical Address Width Adapter

This block connects a 43-bit internal physical address source to a system address bus whose active width is chosen at run time. A one-bit mode register selects a wide (43-bit) or narrow (41-bit) outgoing address. Requests arrive through a valid/ready handshake and are held in a single forwarding register that drives the bus side, which also uses valid/ready.

In narrow mode the two upper address bits are cleared before the address leaves the block. When those dropped bits were not both zero, the address is still forwarded, and a sticky urgent-error bit is raised only once the bus has taken the truncated address. Software clears the bit with a one-cycle clear pulse.

Top module: `pa_width_adapter`

## Requirements
- R1: After a synchronous active-low reset, bus_valid is 0, req_ready is 1, err_flag is 0 and the mode is wide (cfg_mode_in encoding: 1 = wide 43-bit, 0 = narrow 41-bit).
- R2: In wide mode, bus_addr equals the accepted req_addr in all 43 bits, and err_flag is not raised.
- R3: In narrow mode, bus_addr[40:0] equals req_addr[40:0] and bus_addr[42:41] is 0.
- R4: In narrow mode, an address with a nonzero bit in req_addr[42:41] is still forwarded: bus_valid rises and the truncated address is offered to the bus.
- R5: err_flag rises in the cycle after the bus handshake (bus_valid and bus_ready both high) of such an address completes, and not while that address is waiting on the bus.
- R6: err_flag stays set until an err_clr pulse. A clear with no new error in the same cycle returns it to 0 at the next edge.
- R7: If err_clr and the bus handshake of an offending address happen in the same cycle, err_flag is 1 after that edge.
- R8: The mode is sampled when a request is accepted (req_valid and req_ready high). A mode write (cfg_we) in that same cycle, or later, does not affect that request.
- R9: While bus_valid is 1 and bus_ready is 0, bus_addr holds its value and req_ready is 0. req_ready is 1 whenever the forwarding register is empty or bus_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the mode register |
| cfg_mode_in | input | 1 | Mode value written: 1 wide, 0 narrow |
| req_valid | input | 1 | Source offers an address |
| req_ready | output | 1 | Block accepts the offered address |
| req_addr | input | 43 | Internal physical address |
| bus_valid | output | 1 | Address offered to the bus |
| bus_ready | input | 1 | Bus takes the address |
| bus_addr | output | 43 | Outgoing address, upper bits zero in narrow mode |
| err_clr | input | 1 | One-cycle clear of the error bit |
| err_flag | output | 1 | Sticky urgent error: dropped address bits were nonzero |

## Verification
The hardest situations to reach are the ones where the timing of the error matters. These are an offending address parked on a stalled bus, a clear that coincides with its handshake, and a mode write in the same cycle as an acceptance or while an earlier entry waits. The stimulus holds bus_ready low to park entries. It then releases the bus in the same cycle as a clear pulse, and writes the mode register both alongside an acceptance and during a stall. A cycle-level error model in the bench compares err_flag on every cycle against these cases.

// File: rtl/pa_adapt_pkg.sv
// Package: shared mode encoding for the physical address width adapter.
// Assumes a single mode bit; 1 selects the full internal width.
package pa_adapt_pkg;

    typedef enum logic {
        PA_MODE_NARROW = 1'b0,
        PA_MODE_WIDE   = 1'b1
    } pa_mode_e;

    localparam pa_mode_e PA_MODE_RESET = PA_MODE_WIDE;

endpackage

// File: rtl/pa_mode_reg.sv
// Module: pa_mode_reg
// Holds the address width mode. Written by a strobe; reset selects wide mode.
// Assumes the writer keeps cfg_mode_in valid whenever cfg_we is high.
module pa_mode_reg
    import pa_adapt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en,
    input  logic     wr_val,
    output pa_mode_e mode
);

    pa_mode_e mode_q;

    // Purpose: load a new mode on a write, wide mode out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= PA_MODE_RESET;
        end else if (wr_en) begin
            mode_q <= pa_mode_e'(wr_val);
        end
    end

    assign mode = mode_q;

endmodule

// File: rtl/pa_addr_shaper.sv
// Module: pa_addr_shaper
// Narrows an internal address to the selected width and flags nonzero
// dropped bits. Purely combinational.
// Assumes NARROW_AW <= IN_AW.
module pa_addr_shaper
    import pa_adapt_pkg::*;
#(
    parameter int IN_AW     = 43,
    parameter int NARROW_AW = 41
) (
    input  logic [IN_AW-1:0] addr_in,
    input  pa_mode_e         mode,
    output logic [IN_AW-1:0] addr_out,
    output logic             overflow
);

    localparam int DROP_W = IN_AW - NARROW_AW;

    generate
        if (DROP_W > 0) begin : g_drop
            logic [DROP_W-1:0] upper;
            assign upper = addr_in[IN_AW-1:NARROW_AW];

            // Purpose: clear the dropped bits and detect lost information.
            always_comb begin
                addr_out = addr_in;
                overflow = 1'b0;
                if (mode == PA_MODE_NARROW) begin
                    addr_out[IN_AW-1:NARROW_AW] = '0;
                    overflow = |upper;
                end
            end
        end else begin : g_same
            assign addr_out = addr_in;
            assign overflow = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/pa_fwd_stage.sv
// Module: pa_fwd_stage
// One-entry forwarding register between the request and bus handshakes.
// Carries the shaped address, its error tag and the mode it was taken in.
// Assumes the bus side obeys valid/ready: a taken entry is gone next cycle.
module pa_fwd_stage #(
    parameter int AW = 43
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [AW-1:0] in_addr,
    input  logic          in_bad,
    input  logic          in_narrow,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [AW-1:0] out_addr,
    output logic          out_bad,
    output logic          out_narrow
);

    logic          vld_q;
    logic [AW-1:0] addr_q;
    logic          bad_q;
    logic          narrow_q;
    logic          take;

    assign in_ready = !vld_q || out_ready;
    assign take     = in_valid && in_ready;

    // Purpose: occupancy of the single entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
        end else if (in_ready) begin
            vld_q <= in_valid;
        end
    end

    // Purpose: capture the shaped address and its tags on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            bad_q    <= 1'b0;
            narrow_q <= 1'b0;
        end else if (take) begin
            addr_q   <= in_addr;
            bad_q    <= in_bad;
            narrow_q <= in_narrow;
        end
    end

    assign out_valid  = vld_q;
    assign out_addr   = addr_q;
    assign out_bad    = bad_q;
    assign out_narrow = narrow_q;

endmodule

// File: rtl/pa_err_sticky.sv
// Module: pa_err_sticky
// Sticky error bit. A set wins over a clear in the same cycle.
// Assumes set is a single-cycle event per offending transfer.
module pa_err_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);

    logic flag_q;

    // Purpose: hold the error until cleared; new errors take priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= set || (flag_q && !clr);
        end
    end

    assign flag = flag_q;

endmodule

// File: rtl/pa_width_adapter.sv
// Module: pa_width_adapter (top)
// Forwards internal physical addresses to a bus at a run-time selected width.
// In narrow mode it drops the upper bits, still forwards the address, and
// raises a sticky error one cycle after the bus takes an address whose
// dropped bits were nonzero.
// Assumes IN_AW > NARROW_AW and a standard valid/ready bus.
module pa_width_adapter
    import pa_adapt_pkg::*;
#(
    parameter int IN_AW     = 43,
    parameter int NARROW_AW = 41
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_mode_in,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [IN_AW-1:0] req_addr,
    output logic             bus_valid,
    input  logic             bus_ready,
    output logic [IN_AW-1:0] bus_addr,
    input  logic             err_clr,
    output logic             err_flag
);

    pa_mode_e         cur_mode;
    logic [IN_AW-1:0] shaped_addr;
    logic             shaped_bad;
    logic             fwd_bad;
    logic             fwd_narrow;
    logic             err_set;

    pa_mode_reg u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we),
        .wr_val (cfg_mode_in),
        .mode   (cur_mode)
    );

    pa_addr_shaper #(
        .IN_AW     (IN_AW),
        .NARROW_AW (NARROW_AW)
    ) u_shape (
        .addr_in  (req_addr),
        .mode     (cur_mode),
        .addr_out (shaped_addr),
        .overflow (shaped_bad)
    );

    pa_fwd_stage #(
        .AW (IN_AW)
    ) u_fwd (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (req_valid),
        .in_ready   (req_ready),
        .in_addr    (shaped_addr),
        .in_bad     (shaped_bad),
        .in_narrow  (cur_mode == PA_MODE_NARROW),
        .out_valid  (bus_valid),
        .out_ready  (bus_ready),
        .out_addr   (bus_addr),
        .out_bad    (fwd_bad),
        .out_narrow (fwd_narrow)
    );

    // The error is raised by the completed bus transfer, never before it.
    assign err_set = bus_valid && bus_ready && fwd_bad;

    pa_err_sticky u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (err_set),
        .clr   (err_clr),
        .flag  (err_flag)
    );

endmodule

// File: rtl/pa_width_adapter_chk.sv
// Module: pa_width_adapter_chk
// Property checker for pa_width_adapter, attached with bind below.
// Assumes the port and internal names of the top module.
module pa_width_adapter_chk #(
    parameter int IN_AW     = 43,
    parameter int NARROW_AW = 41
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             bus_valid,
    input logic             bus_ready,
    input logic [IN_AW-1:0] bus_addr,
    input logic             err_clr,
    input logic             err_flag,
    input logic             fwd_bad,
    input logic             fwd_narrow
);

    // R9: a stalled entry keeps its address and blocks new requests
    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr)));

    p_stall_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |-> !req_ready);

    // R3: a narrow entry never drives the dropped bits
    p_narrow_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && fwd_narrow) |-> (bus_addr[IN_AW-1:NARROW_AW] == '0));

    // R5: the error only rises after a completed bus transfer
    p_err_after_xfer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> $past(bus_valid && bus_ready));

    // R5: an offending transfer always raises the error next cycle
    p_err_raise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_ready && fwd_bad) |=> err_flag);

    // R6: sticky without a clear
    p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> err_flag);

    // R6: a clear with no new error empties the bit
    p_err_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !(bus_valid && bus_ready && fwd_bad)) |=> !err_flag);

    // R7: a new error beats a simultaneous clear
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && bus_valid && bus_ready && fwd_bad) |=> err_flag);

endmodule

bind pa_width_adapter pa_width_adapter_chk #(
    .IN_AW     (IN_AW),
    .NARROW_AW (NARROW_AW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .bus_valid  (bus_valid),
    .bus_ready  (bus_ready),
    .bus_addr   (bus_addr),
    .err_clr    (err_clr),
    .err_flag   (err_flag),
    .fwd_bad    (fwd_bad),
    .fwd_narrow (fwd_narrow)
);

// File: tb/test_pa_width_adapter.sv
// Bench: scoreboard for pa_width_adapter. The driver pushes the expected
// bus address and error tag per request; the monitor pops on each bus
// handshake and runs a cycle model of the sticky error bit.
module test_pa_width_adapter;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 43;
    localparam int NW         = 41;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          bad;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_we;
    logic          cfg_mode_in;
    logic          req_valid;
    logic          req_ready;
    logic [AW-1:0] req_addr;
    logic          bus_valid;
    logic          bus_ready;
    logic [AW-1:0] bus_addr;
    logic          err_clr;
    logic          err_flag;

    int   n_total = 0;
    int   n_bad   = 0;
    exp_t sb_q[$];
    bit   tb_wide = 1'b1;
    bit   model_err = 1'b0;
    bit   hs_bad_q  = 1'b0;
    bit   clr_q     = 1'b0;
    bit   done      = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pa_width_adapter #(.IN_AW(AW), .NARROW_AW(NW)) i_pa_width_adapter (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_mode_in (cfg_mode_in),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_addr    (req_addr),
        .bus_valid   (bus_valid),
        .bus_ready   (bus_ready),
        .bus_addr    (bus_addr),
        .err_clr     (err_clr),
        .err_flag    (err_flag)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_total++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Offer one address; optionally write the mode in the same cycle.
    task automatic send(input logic [AW-1:0] a, input bit dcfg, input bit dmode);
        exp_t e;
        req_valid   = 1'b1;
        req_addr    = a;
        cfg_we      = dcfg;
        cfg_mode_in = dmode;
        do @(negedge clk); while (!req_ready);
        e.addr = tb_wide ? a : {{(AW-NW){1'b0}}, a[NW-1:0]};
        e.bad  = !tb_wide && (a[AW-1:NW] != '0);
        sb_q.push_back(e);
        @(posedge clk); #1;
        req_valid = 1'b0;
        cfg_we    = 1'b0;
        if (dcfg) tb_wide = dmode;
    endtask

    task automatic set_mode(input bit wide);
        cfg_we      = 1'b1;
        cfg_mode_in = wide;
        @(posedge clk); #1;
        cfg_we  = 1'b0;
        tb_wide = wide;
    endtask

    task automatic pulse_clr();
        err_clr = 1'b1;
        @(posedge clk); #1;
        err_clr = 1'b0;
    endtask

    // Monitor: scoreboard pop on handshakes and cycle model of err_flag.
    always @(negedge clk) begin
        if (!rst_n) begin
            model_err = 1'b0;
            hs_bad_q  = 1'b0;
            clr_q     = 1'b0;
        end else begin
            model_err = hs_bad_q || (model_err && !clr_q);
            check(err_flag == model_err, "R5/R6/R7 err_flag model", 64'(err_flag),
                  64'(model_err));
            hs_bad_q = 1'b0;
            if (bus_valid && bus_ready) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R2 unexpected bus transfer", 64'(bus_addr), 64'd0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(bus_addr == e.addr, "R2/R3/R4/R8 bus_addr", 64'(bus_addr),
                          64'(e.addr));
                    hs_bad_q = e.bad;
                end
            end
            clr_q = err_clr;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 64'd0, 64'd1);
            $display("test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_mode_in = 1'b1; req_valid = 1'b0;
        req_addr = '0; bus_ready = 1'b0; err_clr = 1'b0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(bus_valid == 1'b0, "R1 bus_valid", 64'(bus_valid), 64'd0);
        check(req_ready == 1'b1, "R1 req_ready", 64'(req_ready), 64'd1);
        check(err_flag == 1'b0, "R1 err_flag", 64'(err_flag), 64'd0);
        @(posedge clk); #1;
        bus_ready = 1'b1;

        // R1/R2: default wide mode passes the upper bits, no error
        send(43'h601_2345_6789, 1'b0, 1'b0);
        send(43'h7FF_FFFF_FFFF, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        check(err_flag == 1'b0, "R2 no error in wide mode", 64'(err_flag), 64'd0);

        // R3: narrow mode, in-range addresses
        @(posedge clk); #1;
        set_mode(1'b0);
        send(43'h1AB_CDEF_0123, 1'b0, 1'b0);
        send(43'h0FF_FFFF_FFFF, 1'b0, 1'b0);

        // R4/R6: out-of-range address forwarded, error sticks then clears
        send(43'h455_5555_5555, 1'b0, 1'b0);
        repeat (4) @(negedge clk);
        check(err_flag == 1'b1, "R6 error held", 64'(err_flag), 64'd1);
        @(posedge clk); #1;
        pulse_clr();
        @(negedge clk);
        check(err_flag == 1'b0, "R6 cleared", 64'(err_flag), 64'd0);

        // R5/R9: park an offending address on a stalled bus
        @(posedge clk); #1;
        bus_ready = 1'b0;
        send(43'h200_0000_0001, 1'b0, 1'b0);
        repeat (3) begin
            @(negedge clk);
            check(bus_valid == 1'b1, "R4 offending address offered", 64'(bus_valid), 64'd1);
            check(bus_addr == 43'h000_0000_0001, "R9 held address", 64'(bus_addr),
                  64'h1);
            check(req_ready == 1'b0, "R9 ready low on stall", 64'(req_ready), 64'd0);
            check(err_flag == 1'b0, "R5 no error before transfer", 64'(err_flag), 64'd0);
        end
        @(posedge clk); #1;
        bus_ready = 1'b1;
        @(negedge clk);
        check(err_flag == 1'b0, "R5 handshake cycle", 64'(err_flag), 64'd0);
        @(negedge clk);
        check(err_flag == 1'b1, "R5 raised after transfer", 64'(err_flag), 64'd1);

        // R7: clear coinciding with another offending handshake
        @(posedge clk); #1;
        bus_ready = 1'b0;
        send(43'h600_0000_0777, 1'b0, 1'b0);
        err_clr   = 1'b1;
        bus_ready = 1'b1;
        @(posedge clk); #1;
        err_clr = 1'b0;
        @(negedge clk);
        check(err_flag == 1'b1, "R7 set wins over clear", 64'(err_flag), 64'd1);
        @(posedge clk); #1;
        pulse_clr();
        @(negedge clk);
        check(err_flag == 1'b0, "R6 cleared again", 64'(err_flag), 64'd0);

        // R8: mode change while an entry waits keeps its sampled mode
        @(posedge clk); #1;
        bus_ready = 1'b0;
        send(43'h600_0000_00AA, 1'b0, 1'b0);
        set_mode(1'b1);
        @(negedge clk);
        check(bus_addr == 43'h000_0000_00AA, "R8 queued entry keeps narrow",
              64'(bus_addr), 64'hAA);
        @(posedge clk); #1;
        bus_ready = 1'b1;
        repeat (2) @(negedge clk);
        @(posedge clk); #1;
        pulse_clr();
        // R8: same-cycle write uses the old (wide) mode, next uses narrow
        send(43'h600_0000_00BB, 1'b1, 1'b0);
        send(43'h600_0000_00CC, 1'b0, 1'b0);

        // R9: back-to-back stream with a bus that stalls every other cycle
        set_mode(1'b1);
        fork
            begin
                for (int i = 0; i < 8; i++) send(43'(64'h123_0000_0000 + i), 1'b0, 1'b0);
            end
            begin
                for (int i = 0; i < 16; i++) begin
                    bus_ready = i[0];
                    @(posedge clk); #1;
                end
                bus_ready = 1'b1;
            end
        join
        repeat (5) @(negedge clk);
        check(sb_q.size() == 0, "R9 all requests delivered", 64'(sb_q.size()), 64'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

endmodule